// File: doc/BRIEF.md
# CPU Bus Region Decoder with Interrupt-Acknowledge Detection

This combinational block sits beside a 68000-family processor and turns each bus cycle into one active-low chip select. It looks at the three function-code lines, the top eight address lines (A23 down to A16), the address strobe and the two data strobes. From these it selects the even or odd half of a boot ROM, the even or odd half of the onboard RAM, a peripheral IO window, or the expansion space for every address that nothing else claims. No clock or state is involved. Every output settles from its inputs within the same bus cycle.

The block also recognises interrupt-acknowledge cycles. Function code 111 marks CPU-space cycles in general. Breakpoint and coprocessor cycles use the same code, so the block also requires A19 and A18 high before it treats a cycle as an acknowledge. A17 is deliberately left out of that test. It drives a data strobe for a byte-wide peripheral on the odd lane. That strobe follows the lower data strobe and is also forced during an acknowledge, so the peripheral can place its vector on the bus.

Top module: `bus_region_decoder`

## Requirements
- R1: `iack_n` is low exactly when `as_n` is low, `fc` is 3'b111, `addr_hi[3]` (A19) is 1 and `addr_hi[2]` (A18) is 1. `addr_hi[1]` (A17) has no effect on it. `addr_hi[7]` is A23 and `addr_hi[0]` is A16.
- R2: `io_sel_n` is low exactly when `as_n` is low, `addr_hi[7:2]` is 6'b111110 (0xF80000-0xFBFFFF) and `iack_n` is high.
- R3: For addresses 0xF00000-0xF7FFFF (`addr_hi` 8'hF0 to 8'hF7), `io_sel_n` stays high. A strobed non-acknowledge cycle there asserts `exp_sel_n`.
- R4: For `addr_hi[7:2]` = 6'b111111 (0xFC0000-0xFFFFFF) in a non-acknowledge cycle with `as_n` low, `rom_even_n` equals `uds_n` and `rom_odd_n` equals `lds_n`. Outside that window both stay high.
- R5: For `addr_hi[7:4]` = 4'b0000 (0x000000-0x0FFFFF) in a non-acknowledge cycle with `as_n` low, `ram_even_n` equals `uds_n` and `ram_odd_n` equals `lds_n`. Outside that window both stay high.
- R6: `exp_sel_n` is low exactly when `as_n` is low, `iack_n` is high and the address lies in none of the ROM, RAM and IO windows.
- R7: `per_ds_n` is low exactly when `as_n` is low and either `lds_n` is low or `iack_n` is low. It is high whenever `lds_n` is high outside an acknowledge.
- R8: While `as_n` is high, every output is high, whatever the other inputs are.
- R9: While `as_n` is low, at most one of the regions ROM, RAM, IO and expansion selects, and during an acknowledge none of them does. With at least one data strobe low, exactly one region selects, or `iack_n` alone is low.
- R10: Every output is always driven to 0 or 1, never unknown or high-impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fc | input | 3 | Processor function code, bit 2 is FC2 |
| addr_hi | input | 8 | Address lines A23 (bit 7) to A16 (bit 0) |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper (even byte) data strobe, active low |
| lds_n | input | 1 | Lower (odd byte) data strobe, active low |
| rom_even_n | output | 1 | Even-byte ROM select, active low |
| rom_odd_n | output | 1 | Odd-byte ROM select, active low |
| ram_even_n | output | 1 | Even-byte RAM select, active low |
| ram_odd_n | output | 1 | Odd-byte RAM select, active low |
| io_sel_n | output | 1 | IO window select, active low |
| exp_sel_n | output | 1 | Expansion space select, active low |
| per_ds_n | output | 1 | Odd-lane peripheral data strobe, active low |
| iack_n | output | 1 | Interrupt-acknowledge detected, active low |

## Verification
Two functions can land on the same cycle here. An interrupt-acknowledge cycle may carry an address that also falls inside the ROM, IO or expansion window, and acknowledge detection must then suppress the region decode while still forcing the peripheral strobe. The bench provokes this by sweeping every function code against every value of A23..A16 under each strobe combination, including the cycles where A17 alone is high. For each vector it compares all eight outputs with a model built from the requirements, and it checks that at most one region fires.

// File: rtl/bus_decode_pkg.sv
package bus_decode_pkg;
  localparam int unsigned ADDR_HI_W = 8;
  localparam int unsigned FC_W      = 3;
  localparam int unsigned LANES     = 2;
  localparam logic [FC_W-1:0] FC_CPU_SPACE = 3'b111;
  localparam logic [ADDR_HI_W-1:0] ROM_BASE = 8'hFC;
  localparam logic [ADDR_HI_W-1:0] ROM_MASK = 8'hFC;
  localparam logic [ADDR_HI_W-1:0] RAM_BASE = 8'h00;
  localparam logic [ADDR_HI_W-1:0] RAM_MASK = 8'hF0;
  localparam logic [ADDR_HI_W-1:0] IO_BASE  = 8'hF8;
  localparam logic [ADDR_HI_W-1:0] IO_MASK  = 8'hFC;
  localparam logic [ADDR_HI_W-1:0] ACK_BITS = 8'h0C;
endpackage

// File: rtl/cpu_space_detect.sv
module cpu_space_detect
  import bus_decode_pkg::*;
#(
  parameter logic [ADDR_HI_W-1:0] QUAL_BITS = ACK_BITS
) (
  input  logic [FC_W-1:0]      fc,
  input  logic [ADDR_HI_W-1:0] addr_hi,
  input  logic                 strobe,
  output logic                 ack
);
  logic cpu_space;
  logic qual_ok;

  assign cpu_space = (fc == FC_CPU_SPACE);
  assign qual_ok   = ((addr_hi & QUAL_BITS) == QUAL_BITS);
  assign ack       = strobe & cpu_space & qual_ok;

  always_comb begin
    if (ack) begin
      AST_ACK_NEEDS_CPU_SPACE: assert (fc == 3'b111 && addr_hi[3] && addr_hi[2]); // R1
    end
  end
endmodule

// File: rtl/window_match.sv
module window_match
  import bus_decode_pkg::*;
#(
  parameter logic [ADDR_HI_W-1:0] BASE = 8'h00,
  parameter logic [ADDR_HI_W-1:0] MASK = 8'hFF
) (
  input  logic [ADDR_HI_W-1:0] addr_hi,
  output logic                 hit
);
  logic [ADDR_HI_W-1:0] bit_ok;

  for (genvar i = 0; i < ADDR_HI_W; i++) begin : g_bit
    if (MASK[i]) begin : g_care
      assign bit_ok[i] = (addr_hi[i] == BASE[i]);
    end else begin : g_dont
      assign bit_ok[i] = 1'b1;
    end
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/lane_split.sv
module lane_split
  import bus_decode_pkg::*;
#(
  parameter int unsigned N = LANES
) (
  input  logic         hit,
  input  logic         en,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] sel_n
);
  for (genvar l = 0; l < N; l++) begin : g_lane
    assign sel_n[l] = ~(hit & en & ~strobe_n[l]);
  end
endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
  import bus_decode_pkg::*;
(
  input  logic [2:0] fc,
  input  logic [7:0] addr_hi,
  input  logic       as_n,
  input  logic       uds_n,
  input  logic       lds_n,
  output logic       rom_even_n,
  output logic       rom_odd_n,
  output logic       ram_even_n,
  output logic       ram_odd_n,
  output logic       io_sel_n,
  output logic       exp_sel_n,
  output logic       per_ds_n,
  output logic       iack_n
);
  logic strobe, ack, mem_en;
  logic rom_hit, ram_hit, io_hit, any_hit;
  logic [LANES-1:0] rom_sel_n, ram_sel_n;

  assign strobe = ~as_n;

  cpu_space_detect u_ack (
    .fc(fc), .addr_hi(addr_hi), .strobe(strobe), .ack(ack)
  );

  window_match #(.BASE(ROM_BASE), .MASK(ROM_MASK)) u_rom_win (
    .addr_hi(addr_hi), .hit(rom_hit)
  );
  window_match #(.BASE(RAM_BASE), .MASK(RAM_MASK)) u_ram_win (
    .addr_hi(addr_hi), .hit(ram_hit)
  );
  window_match #(.BASE(IO_BASE), .MASK(IO_MASK)) u_io_win (
    .addr_hi(addr_hi), .hit(io_hit)
  );

  assign mem_en  = strobe & ~ack;
  assign any_hit = rom_hit | ram_hit | io_hit;

  lane_split #(.N(LANES)) u_rom_lanes (
    .hit(rom_hit), .en(mem_en), .strobe_n({uds_n, lds_n}), .sel_n(rom_sel_n)
  );
  lane_split #(.N(LANES)) u_ram_lanes (
    .hit(ram_hit), .en(mem_en), .strobe_n({uds_n, lds_n}), .sel_n(ram_sel_n)
  );

  assign rom_even_n = rom_sel_n[1];
  assign rom_odd_n  = rom_sel_n[0];
  assign ram_even_n = ram_sel_n[1];
  assign ram_odd_n  = ram_sel_n[0];
  assign io_sel_n   = ~(mem_en & io_hit);
  assign exp_sel_n  = ~(mem_en & ~any_hit);
  assign per_ds_n   = ~(strobe & (~lds_n | ack));
  assign iack_n     = ~ack;

  always_comb begin
    if (as_n) begin
      AST_IDLE_QUIET: assert (&{rom_even_n, rom_odd_n, ram_even_n, ram_odd_n,
                                io_sel_n, exp_sel_n, per_ds_n, iack_n}); // R8
    end
    AST_ONE_REGION: assert ($countones({~(rom_even_n & rom_odd_n), ~(ram_even_n & ram_odd_n),
                                        ~io_sel_n, ~exp_sel_n}) <= 1); // R9
    if (!iack_n) begin
      AST_ACK_EXCLUDES_MEM: assert (&{rom_even_n, rom_odd_n, ram_even_n, ram_odd_n,
                                      io_sel_n, exp_sel_n}); // R9
      AST_ACK_DRIVES_PERDS: assert (!per_ds_n); // R7
    end
    if (!io_sel_n) begin
      AST_IO_WINDOW: assert (addr_hi[7:2] == 6'b111110); // R2
    end
    if (lds_n && iack_n) begin
      AST_PERDS_RELEASED: assert (per_ds_n); // R7
    end
  end
endmodule

// File: tb/bus_region_decoder_test.sv
`timescale 1ns/1ps
module bus_region_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0] fc = 3'b000;
  logic [7:0] addr_hi = 8'h00;
  logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
  logic rom_even_n, rom_odd_n, ram_even_n, ram_odd_n;
  logic io_sel_n, exp_sel_n, per_ds_n, iack_n;

  bus_region_decoder uut (
    .fc(fc), .addr_hi(addr_hi), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rom_even_n(rom_even_n), .rom_odd_n(rom_odd_n),
    .ram_even_n(ram_even_n), .ram_odd_n(ram_odd_n),
    .io_sel_n(io_sel_n), .exp_sel_n(exp_sel_n),
    .per_ds_n(per_ds_n), .iack_n(iack_n)
  );

  // outputs captured on the clock for checking only
  logic [7:0] cap;
  always_ff @(posedge clk) begin
    if (rst) cap <= 8'hFF;
    else cap <= {iack_n, rom_even_n, rom_odd_n, ram_even_n, ram_odd_n,
                 io_sel_n, exp_sel_n, per_ds_n};
  end

  int checks = 0;
  int fails  = 0;
  bit summary_done = 1'b0;

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
  endtask

  function automatic logic [7:0] model(input logic [2:0] f, input logic [7:0] a,
                                       input logic as, input logic u, input logic l);
    logic st, ack, rom, ram, io, en;
    st  = ~as;
    ack = st && f == 3'b111 && a[3] && a[2];         // R1
    rom = (a[7:2] == 6'b111111);                      // R4
    ram = (a[7:4] == 4'b0000);                        // R5
    io  = (a[7:2] == 6'b111110);                      // R2
    en  = st && !ack;
    return {~ack, ~(en && rom && !u), ~(en && rom && !l),
            ~(en && ram && !u), ~(en && ram && !l),
            ~(en && io), ~(en && !(rom || ram || io)),
            ~(st && (!l || ack))};                    // R6 R7
  endfunction

  function automatic string tag_for(input logic [7:0] diff, input logic as,
                                    input logic [7:0] a);
    if (as) return "R8";
    if (diff[7]) return "R1";
    if (diff[6] || diff[5]) return "R4";
    if (diff[4] || diff[3]) return "R5";
    if (diff[2]) return (a[7:3] == 5'b11110) ? "R3" : "R2";
    if (diff[1]) return "R6";
    return "R7";
  endfunction

  task automatic apply(input logic [2:0] f, input logic [7:0] a,
                       input logic as, input logic u, input logic l);
    logic [7:0] exp_v;
    int regions;
    fc = f; addr_hi = a; as_n = as; uds_n = u; lds_n = l;
    @(posedge clk);
    #1;
    exp_v = model(f, a, as, u, l);
    checks++;
    if (cap !== exp_v) begin
      fails++;
      $display("FAIL %s fc=%b a=%h as=%b uds=%b lds=%b got %b expected %b",
               tag_for(cap ^ exp_v, as, a), f, a, as, u, l, cap, exp_v);
    end
    checks++;
    if ($isunknown(cap)) begin
      fails++;
      $display("FAIL R10 fc=%b a=%h got %b expected no unknown bits", f, a, cap);
    end
    regions = int'(!(cap[6] & cap[5])) + int'(!(cap[4] & cap[3])) +
              int'(!cap[2]) + int'(!cap[1]);
    if (!as && !(u && l)) begin
      checks++;
      if ((cap[7] && regions != 1) || (!cap[7] && regions != 0)) begin
        fails++;
        $display("FAIL R9 fc=%b a=%h got %0d regions iack_n=%b expected %0d",
                 f, a, regions, cap[7], cap[7] ? 1 : 0);
      end
    end
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    checks++;
    if (cap !== 8'hFF) begin
      fails++;
      $display("FAIL R8 reset state got %b expected %b", cap, 8'hFF);
    end
  endtask

  task automatic t_sweep();
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 256; a++)
        for (int s = 0; s < 8; s++)
          apply(3'(f), 8'(a), s[2], s[1], s[0]);
  endtask

  task automatic t_io_edges();
    // R3: hole below the IO window goes to expansion, R2: edges of the window
    apply(3'b101, 8'hF0, 1'b0, 1'b1, 1'b0);
    apply(3'b101, 8'hF7, 1'b0, 1'b0, 1'b0);
    apply(3'b101, 8'hF8, 1'b0, 1'b1, 1'b0);
    apply(3'b101, 8'hFB, 1'b0, 1'b1, 1'b0);
    apply(3'b110, 8'hFC, 1'b0, 1'b0, 1'b1);
    apply(3'b001, 8'h0F, 1'b0, 1'b1, 1'b0);
    apply(3'b001, 8'h10, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_cpu_space_variants();
    // R1: A17 alone high is not an acknowledge; A19 and A18 are required
    apply(3'b111, 8'hF2, 1'b0, 1'b1, 1'b0);
    apply(3'b111, 8'hFE, 1'b0, 1'b1, 1'b1);
    apply(3'b111, 8'hF4, 1'b0, 1'b1, 1'b1);
    apply(3'b111, 8'hFF, 1'b1, 1'b0, 1'b0);
    apply(3'b011, 8'hFF, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_perds_release();
    // R7: strobe released between odd accesses
    apply(3'b101, 8'hF8, 1'b0, 1'b1, 1'b0);
    apply(3'b101, 8'hF8, 1'b0, 1'b0, 1'b1);
    apply(3'b101, 8'hF8, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    t_reset_state();
    @(negedge clk);
    t_cpu_space_variants();
    t_io_edges();
    t_perds_release();
    t_sweep();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got running expected finished");
    summary();
    $finish;
  end
endmodule